// File: doc/BRIEF.md
# Pipelined Synchronous Burst Static Memory

This block is a synthesizable single-port static memory with a 64-bit word split into byte lanes and a parameterized number of words. Every control, address and data input is sampled on the rising clock edge into an input stage. The memory is updated or read from that stage, and read data then passes through an output register. A read therefore appears on the output two rising edges after its address was presented. The shared data bus is modelled as a write-data input, a read-data output and a flag that says whether the read data is being driven.

An access is opened by one of two start strobes. `start_rd` always reads and takes priority. `start_acc` reads or writes depending on the write controls. The start cycle loads a burst base address. The following cycles need no strobe: they either step a 2-bit burst offset (`adv` high) or repeat the current address (`adv` low). The offset sequence is a wrapping increment or an XOR with the base, as chosen by `burst_lin`. Three chip enables of mixed polarity are sampled on start cycles only, and the resulting selection is held for the rest of the burst.

The output enable and the sleep input act on the output without waiting for a clock. While sleep is high, and for a parameterized number of edges after it falls, the block accepts no access and drops any open burst.

Top module: `sram_pipe_burst`

## Requirements
- R1: A read whose address is sampled at rising edge t drives its word on `rdata` with `rdata_vld` high after edge t+1, provided `out_en` is high and `sleep` is low.
- R2: A start cycle selects the block only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Otherwise that start and every following strobe-free cycle make no access and produce no driven output, until the next selected start.
- R3: On a writing cycle, `wr_all`=1 writes all eight lanes. Otherwise, with `wr_en`=1, bit i of `byte_we` writes bits [8i+7:8i]. With `wr_en`=0, `byte_we` has no effect and the cycle is a read.
- R4: `start_rd` always performs a read, even when the write controls request a write, and wins when both strobes are high. `start_acc` uses the write controls.
- R5: With `burst_lin`=1, the k-th advance gives the address whose two low bits are (base + k) mod 4, with the upper bits taken from the base.
- R6: With `burst_lin`=0, the k-th advance gives the address whose two low bits are base XOR k, with the upper bits taken from the base.
- R7: A strobe-free selected cycle with `adv`=0 accesses the same address as the previous cycle, whether that access is a read or a write.
- R8: While `out_en` is low, `rdata_vld` is 0 and `rdata` is all zeros within the same cycle. A pending read word is driven again as soon as `out_en` returns high.
- R9: While `sleep` is high, output is not driven and no access is made. After it falls, the next WAKE_CYC rising edges ignore all strobes. Any open burst must be restarted.
- R10: A write or a deselected cycle leaves `rdata_vld` low two edges later, and a deselected write leaves the array unchanged.
- R11: After reset the output is not driven and the block is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Asynchronous power-down request |
| addr | input | ADDR_W | Word address for start cycles |
| wdata | input | DATA_W | Write data |
| start_rd | input | 1 | Start strobe that always reads |
| start_acc | input | 1 | Start strobe that reads or writes |
| adv | input | 1 | Step burst offset on strobe-free cycles |
| burst_lin | input | 1 | 1: wrapping increment order, 0: XOR order |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| wr_all | input | 1 | Write every lane |
| wr_en | input | 1 | Qualifies the per-lane write bits |
| byte_we | input | DATA_W/LANE_W | Per-lane write bits |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | DATA_W | Registered read word, zero when not driven |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
The bound checker watches, on every clock, the relations that follow from the ports alone. These are: a selected read start turns into driven data exactly two edges later; deselected starts, write starts and cycles inside the wake-up window never drive the output; `out_en` and `sleep` blank the output at once. Which word comes back, the lane merge of partial writes, both burst orders, the suspend repeat, the array being left untouched by deselected writes, and the exact length of the wake-up window can only be shown by the bench scenarios. There, a behavioural model tracks memory contents and compares both outputs every cycle.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

   // Kind of access held in the input stage.
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              start,
   input  logic              sel_in,
   input  logic              adv,
   input  logic              linear,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              sel_q,
   output logic [ADDR_W-1:0] eff_addr
);

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_use;
   logic [BURST_W-1:0] low_pos;
   logic [ADDR_W-1:0]  burst_addr;

   // Offset used this cycle: stepped on advance, held on suspend.
   always_comb begin
      cnt_use = adv ? cnt_q + BURST_W'(1) : cnt_q;
      if (linear)
         low_pos = base_q[BURST_W-1:0] + cnt_use;
      else
         low_pos = base_q[BURST_W-1:0] ^ cnt_use;
   end

   generate
      if (BURST_W == ADDR_W) begin : g_full_wrap
         assign burst_addr = low_pos;
      end else begin : g_part_wrap
         assign burst_addr = {base_q[ADDR_W-1:BURST_W], low_pos};
      end
   endgenerate

   assign eff_addr = start ? addr_in : burst_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (hold) begin
         sel_q  <= 1'b0;
      end else if (start) begin
         sel_q  <= sel_in;
         base_q <= addr_in;
         cnt_q  <= '0;
      end else if (sel_q) begin
         cnt_q  <= cnt_use;
      end
   end

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
   import sram_pipe_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 64,
   parameter int LANES    = 8,
   parameter int WAKE_CYC = 4,
   localparam int WAKE_W  = $clog2(WAKE_CYC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic              start_rd,
   input  logic              start_acc,
   input  logic              cs_match,
   input  logic              sel_q,
   input  logic [ADDR_W-1:0] eff_addr,
   input  logic              wr_all,
   input  logic              wr_en,
   input  logic [LANES-1:0]  byte_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              awake,
   output acc_kind_e         s1_kind,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_lanes,
   output logic [DATA_W-1:0] s1_wdata
);

   logic [WAKE_W-1:0] wake_q;
   logic              go;
   logic              wr_req;
   logic [LANES-1:0]  lane_sel;
   acc_kind_e         kind_d;

   // Wake-up window counter, reloaded while sleep is high.
   always_ff @(posedge clk) begin
      if (!rst_n)
         wake_q <= '0;
      else if (sleep)
         wake_q <= WAKE_W'(WAKE_CYC);
      else if (wake_q != '0)
         wake_q <= wake_q - WAKE_W'(1);
   end

   assign awake = !sleep && (wake_q == '0);

   always_comb begin
      go       = awake && ((start_rd || start_acc) ? cs_match : sel_q);
      wr_req   = !start_rd && (wr_all || (wr_en && (byte_we != '0)));
      lane_sel = wr_all ? '1 : (wr_en ? byte_we : '0);
      if (!go)
         kind_d = ACC_IDLE;
      else if (wr_req)
         kind_d = ACC_WRITE;
      else
         kind_d = ACC_READ;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         s1_kind <= ACC_IDLE;
      else
         s1_kind <= kind_d;
   end

   always_ff @(posedge clk) begin
      s1_addr  <= eff_addr;
      s1_lanes <= lane_sel;
      s1_wdata <= wdata;
   end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] rd_q
);

   logic [LANE_W-1:0] cells [DEPTH];

   // Array write from the input stage, and the output register.
   always_ff @(posedge clk) begin
      if (wr_stb)
         cells[addr] <= wd;
      if (rd_stb)
         rd_q <= cells[addr];
   end

endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
   import sram_pipe_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 64,
   parameter int LANE_W   = 8,
   parameter int BURST_W  = 2,
   parameter int WAKE_CYC = 4,
   localparam int LANES   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              start_rd,
   input  logic              start_acc,
   input  logic              adv,
   input  logic              burst_lin,
   input  logic              cs_a_n,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              wr_all,
   input  logic              wr_en,
   input  logic [LANES-1:0]  byte_we,
   input  logic              out_en,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_vld
);

   generate
      if ((DATA_W % LANE_W) != 0) begin : g_bad_lane
         $error("DATA_W must be a multiple of LANE_W");
      end
      if ((BURST_W < 1) || (BURST_W > ADDR_W)) begin : g_bad_burst
         $error("BURST_W must lie between 1 and ADDR_W");
      end
      if (WAKE_CYC < 1) begin : g_bad_wake
         $error("WAKE_CYC must be at least 1");
      end
   endgenerate

   logic              cs_match;
   logic              awake;
   logic              sel_q;
   logic [ADDR_W-1:0] eff_addr;
   acc_kind_e         s1_kind;
   logic [ADDR_W-1:0] s1_addr;
   logic [LANES-1:0]  s1_lanes;
   logic [DATA_W-1:0] s1_wdata;
   logic [DATA_W-1:0] rd_word;
   logic              out_live;

   assign cs_match = !cs_a_n && cs_b && !cs_c_n;

   sram_burst_seq #(
      .ADDR_W  (ADDR_W),
      .BURST_W (BURST_W)
   ) burst_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (!awake),
      .start    (start_rd || start_acc),
      .sel_in   (cs_match),
      .adv      (adv),
      .linear   (burst_lin),
      .addr_in  (addr),
      .sel_q    (sel_q),
      .eff_addr (eff_addr)
   );

   sram_access_ctrl #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .LANES    (LANES),
      .WAKE_CYC (WAKE_CYC)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep     (sleep),
      .start_rd  (start_rd),
      .start_acc (start_acc),
      .cs_match  (cs_match),
      .sel_q     (sel_q),
      .eff_addr  (eff_addr),
      .wr_all    (wr_all),
      .wr_en     (wr_en),
      .byte_we   (byte_we),
      .wdata     (wdata),
      .awake     (awake),
      .s1_kind   (s1_kind),
      .s1_addr   (s1_addr),
      .s1_lanes  (s1_lanes),
      .s1_wdata  (s1_wdata)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         sram_lane_bank #(
            .ADDR_W (ADDR_W),
            .LANE_W (LANE_W)
         ) bank_i (
            .clk    (clk),
            .wr_stb ((s1_kind == ACC_WRITE) && s1_lanes[g]),
            .rd_stb (s1_kind == ACC_READ),
            .addr   (s1_addr),
            .wd     (s1_wdata[g*LANE_W +: LANE_W]),
            .rd_q   (rd_word[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   // Selection delayed to line up with the output register.
   always_ff @(posedge clk) begin
      if (!rst_n)
         out_live <= 1'b0;
      else
         out_live <= (s1_kind == ACC_READ);
   end

   assign rdata_vld = out_live && out_en && !sleep;
   assign rdata     = rdata_vld ? rd_word : '0;

endmodule

// File: rtl/sram_pipe_burst_chk.sv
module sram_pipe_burst_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_rd,
   input logic              start_acc,
   input logic              cs_a_n,
   input logic              cs_b,
   input logic              cs_c_n,
   input logic              wr_all,
   input logic              out_en,
   input logic              sleep,
   input logic              awake,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_vld
);

   logic cs_ok;
   assign cs_ok = !cs_a_n && cs_b && !cs_c_n;

   // R1: selected read start gives driven data two edges later
   a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (start_rd && cs_ok && awake) |=> ##1 (rdata_vld || !out_en || sleep));

   // R2: deselected start never produces driven data
   a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_rd || start_acc) && !cs_ok && awake) |=> ##1 !rdata_vld);

   // R8: output enable low blanks the bus
   a_r8_oe_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (!rdata_vld && (rdata == '0)));

   // R9: sleep blanks the bus
   a_r9_sleep_blank: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rdata_vld);

   // R9: strobes inside the sleep or wake-up window do not reach the output
   a_r9_wake_window: assert property (@(posedge clk) disable iff (!rst_n)
      !awake |=> ##1 !rdata_vld);

   // R10: a selected write start leaves the bus undriven
   a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (start_acc && !start_rd && wr_all && cs_ok && awake) |=> ##1 !rdata_vld);

endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(
   .DATA_W (DATA_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_rd  (start_rd),
   .start_acc (start_acc),
   .cs_a_n    (cs_a_n),
   .cs_b      (cs_b),
   .cs_c_n    (cs_c_n),
   .wr_all    (wr_all),
   .out_en    (out_en),
   .sleep     (sleep),
   .awake     (awake),
   .rdata     (rdata),
   .rdata_vld (rdata_vld)
);

// File: tb/sram_pipe_burst_tb_top.sv
`timescale 1ns/1ps
module sram_pipe_burst_tb_top;

   localparam int AW = 6;
   localparam int DW = 64;
   localparam int NL = 8;
   localparam int WAKE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          start_rd = 1'b0;
   logic          start_acc = 1'b0;
   logic          adv = 1'b0;
   logic          burst_lin = 1'b1;
   logic          cs_a_n = 1'b0;
   logic          cs_b = 1'b1;
   logic          cs_c_n = 1'b0;
   logic          wr_all = 1'b0;
   logic          wr_en = 1'b0;
   logic [NL-1:0] byte_we = '0;
   logic          out_en = 1'b1;
   logic [DW-1:0] rdata;
   logic          rdata_vld;

   int    n_chk = 0;
   int    n_err = 0;
   bit    chk_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R11";
   logic [DW-1:0] shadow [64];

   always #2 clk = ~clk;

   sram_pipe_burst dut_i (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr), .wdata(wdata),
      .start_rd(start_rd), .start_acc(start_acc), .adv(adv), .burst_lin(burst_lin),
      .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .wr_all(wr_all), .wr_en(wr_en),
      .byte_we(byte_we), .out_en(out_en), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   // ---------------- behavioural reference model ----------------
   logic [DW-1:0] mm [int];
   bit            m_sel, p_valid, p_wr, o_live;
   int            m_base, m_cnt, m_wake, p_addr;
   logic [DW-1:0] p_data, o_data;
   logic [NL-1:0] p_be;

   always @(posedge clk) begin : model
      bit cs, wreq, aw;
      int lo;
      logic [NL-1:0] be;
      if (!rst_n) begin
         m_sel = 0; p_valid = 0; o_live = 0; m_wake = 0; m_cnt = 0; m_base = 0;
      end else begin
         if (p_valid) begin
            if (!mm.exists(p_addr)) mm[p_addr] = '0;
            if (p_wr) begin
               for (int k = 0; k < NL; k++)
                  if (p_be[k]) mm[p_addr][k*8 +: 8] = p_data[k*8 +: 8];
               o_live = 0;
            end else begin
               o_live = 1;
               o_data = mm[p_addr];
            end
         end else begin
            o_live = 0;
         end
         aw = !sleep && (m_wake == 0);
         m_wake = sleep ? WAKE : ((m_wake > 0) ? m_wake - 1 : 0);
         cs = !cs_a_n && cs_b && !cs_c_n;
         wreq = wr_all || (wr_en && (byte_we != 0));
         be = wr_all ? '1 : (wr_en ? byte_we : '0);
         p_valid = 0;
         if (!aw) begin
            m_sel = 0;
         end else if (start_rd || start_acc) begin
            m_sel = cs; m_base = int'(addr); m_cnt = 0;
            if (cs) begin
               p_valid = 1; p_addr = int'(addr); p_wr = !start_rd && wreq;
            end
         end else if (m_sel) begin
            if (adv) m_cnt = (m_cnt + 1) % 4;
            lo = burst_lin ? ((m_base + m_cnt) % 4) : ((m_base % 4) ^ m_cnt);
            p_addr = (m_base / 4) * 4 + lo;
            p_valid = 1; p_wr = wreq;
         end
         p_data = wdata; p_be = be;
      end
   end

   task automatic expect_out(input bit v, input logic [DW-1:0] d, input string req);
      n_chk++;
      if (rdata_vld !== v || rdata !== d) begin
         n_err++;
         $display("FAIL %s: actual vld=%0b data=%h expected vld=%0b data=%h",
                  req, rdata_vld, rdata, v, d);
      end
   endtask

   always @(negedge clk) begin : cmp
      bit ev;
      if (chk_on && !done) begin
         ev = o_live && out_en && !sleep;
         expect_out(ev, ev ? o_data : '0, {cur_req, " per-cycle model"});
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [DW-1:0] pat(input int a);
      return {16'hC0DE, 16'(a), 16'h5A00 | 16'(a), 16'(a * 7 + 3)};
   endfunction

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic clr();
      start_rd = 0; start_acc = 0; adv = 0; wr_all = 0; wr_en = 0; byte_we = '0;
   endtask

   task automatic park();
      clr(); start_rd = 1; cs_b = 0;
      step();
      start_rd = 0; cs_b = 1;
   endtask

   task automatic wr_one(input int a, input logic [DW-1:0] d);
      clr(); start_acc = 1; wr_all = 1; addr = AW'(a); wdata = d;
      step();
      shadow[a] = d;
      park();
   endtask

   task automatic rd_one(input int a, input string req);
      clr(); start_rd = 1; addr = AW'(a);
      step();
      park();
      expect_out(1, shadow[a], req);
      step();
      expect_out(0, '0, req);
   endtask

   // start read at base, then three strobe-free cycles with adv pattern
   task automatic burst_chk(input int base, input bit lin, input logic [2:0] ap,
                            input int e0, input int e1, input int e2, input int e3,
                            input string req);
      int exp_a [4];
      exp_a[0] = e0; exp_a[1] = e1; exp_a[2] = e2; exp_a[3] = e3;
      burst_lin = lin;
      for (int k = 0; k < 6; k++) begin
         clr();
         if (k == 0) begin
            start_rd = 1; addr = AW'(base);
         end else if (k <= 3) begin
            adv = ap[k-1];
         end
         if (k == 4) park();
         else step();
         if (k >= 1 && k <= 4) expect_out(1, shadow[exp_a[k-1]], req);
         if (k == 5) expect_out(0, '0, req);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_err++;
         $display("FAIL watchdog: actual run still busy, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      logic [DW-1:0] merged;
      rst_n = 0;
      repeat (3) step();
      rst_n = 1;
      chk_on = 1;
      step();
      cur_req = "R11";
      expect_out(0, '0, "R11 reset output undriven");
      clr(); adv = 1;
      step();
      step();
      expect_out(0, '0, "R11 deselected after reset");

      // R3 global write fill through the write-capable strobe
      cur_req = "R3";
      for (int a = 0; a < 24; a++) wr_one(a, pat(a));

      // R1 read latency, explicit cycle by cycle
      cur_req = "R1";
      clr(); start_rd = 1; addr = AW'(5);
      step();
      expect_out(0, '0, "R1 nothing after first edge");
      park();
      expect_out(1, pat(5), "R1 data after second edge");
      rd_one(17, "R1");

      // R4 read strobe ignores write controls and wins over the other strobe
      cur_req = "R4";
      clr(); start_rd = 1; start_acc = 1; wr_all = 1; addr = AW'(6); wdata = '1;
      step();
      park();
      expect_out(1, shadow[6], "R4 read strobe reads");
      step();
      rd_one(6, "R4 array untouched");

      // R3 lane writes
      cur_req = "R3";
      clr(); start_acc = 1; wr_en = 1; byte_we = 8'hA5; addr = AW'(3); wdata = '1;
      step();
      park();
      merged = pat(3);
      for (int k = 0; k < NL; k++)
         if (k == 0 || k == 2 || k == 5 || k == 7) merged[k*8 +: 8] = 8'hFF;
      shadow[3] = merged;
      rd_one(3, "R3 lane merge");
      clr(); start_acc = 1; wr_en = 0; byte_we = 8'hFF; addr = AW'(4); wdata = '1;
      step();
      park();
      expect_out(1, shadow[4], "R3 lane bits without qualifier read");
      step();

      // R5 wrapping increment, R6 XOR order, R7 suspend
      cur_req = "R5";
      burst_chk(6, 1'b1, 3'b111, 6, 7, 4, 5, "R5 linear order");
      cur_req = "R6";
      burst_chk(5, 1'b0, 3'b111, 5, 4, 7, 6, "R6 xor order");
      burst_chk(10, 1'b0, 3'b111, 10, 11, 8, 9, "R6 xor order upper base");
      cur_req = "R7";
      burst_chk(9, 1'b1, 3'b100, 9, 9, 9, 10, "R7 suspend repeats");

      // R7/R5 burst write then read back
      cur_req = "R7";
      burst_lin = 1;
      clr(); start_acc = 1; wr_all = 1; addr = AW'(12); wdata = pat(112);
      step();
      clr(); wr_all = 1; adv = 0; wdata = pat(212);
      step();
      clr(); wr_all = 1; adv = 1; wdata = pat(113);
      step();
      park();
      shadow[12] = pat(212); shadow[13] = pat(113);
      rd_one(12, "R7 suspended write overwrote same word");
      rd_one(13, "R5 burst write stepped");

      // R2 each enable wrong, R10 deselected write leaves array
      cur_req = "R2";
      for (int e = 0; e < 3; e++) begin
         clr(); start_rd = 1; addr = AW'(5);
         cs_a_n = (e == 0); cs_b = (e != 1); cs_c_n = (e == 2);
         step();
         clr(); adv = 1;
         step();
         expect_out(0, '0, "R2 deselected start");
         step();
         expect_out(0, '0, "R2 deselected burst");
         cs_a_n = 0; cs_b = 1; cs_c_n = 0;
      end
      cur_req = "R10";
      clr(); start_acc = 1; wr_all = 1; addr = AW'(2); wdata = '0; cs_c_n = 1;
      step();
      clr(); adv = 1; wr_all = 1;
      step();
      cs_c_n = 0;
      clr();
      step();
      rd_one(2, "R10 deselected write ignored");
      clr(); start_acc = 1; wr_all = 1; addr = AW'(20); wdata = pat(320);
      step();
      park();
      expect_out(0, '0, "R10 write not driven");
      shadow[20] = pat(320);
      rd_one(20, "R10 write landed");

      // R8 asynchronous output enable
      cur_req = "R8";
      clr(); start_rd = 1; addr = AW'(7);
      step();
      park();
      expect_out(1, shadow[7], "R8 before disable");
      out_en = 0; #0.4;
      expect_out(0, '0, "R8 disabled mid-cycle");
      out_en = 1; #0.4;
      expect_out(1, shadow[7], "R8 re-enabled keeps word");
      step();

      // R9 sleep, wake-up window
      cur_req = "R9";
      clr(); start_rd = 1; addr = AW'(8);
      step();
      park();
      sleep = 1; #0.4;
      expect_out(0, '0, "R9 sleep blanks mid-cycle");
      sleep = 0; #0.4;
      expect_out(1, shadow[8], "R9 short pulse before edge");
      step();
      burst_lin = 1;
      clr(); start_rd = 1; addr = AW'(0);
      step();
      clr(); adv = 1; sleep = 1;
      step();
      clr(); start_acc = 1; wr_all = 1; addr = AW'(1); wdata = '1;
      step();
      expect_out(0, '0, "R9 asleep");
      sleep = 0;
      clr(); adv = 1;
      for (int w = 0; w < WAKE; w++) begin
         step();
         expect_out(0, '0, "R9 wake window burst dropped");
      end
      clr(); start_rd = 1; addr = AW'(1); sleep = 1;
      step();
      sleep = 0;
      for (int w = 0; w < WAKE; w++) begin
         start_rd = 1; addr = AW'(1);
         step();
      end
      clr();
      step();
      expect_out(0, '0, "R9 strobes in window ignored");
      rd_one(1, "R9 write during sleep ignored");

      clr();
      repeat (2) step();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule